// File: doc/BRIEF.md
# Dual-Mode Shared Multiply-Add Cell

This cell is one processing element of an output-stationary systolic matrix array. It can also be lent to a vector engine as one multiply-add lane. The cell contains a single signed multiply-add expression, `x * y + z`. A mode register chooses where each of the three operands comes from, so the two uses share one hardware multiplier.

In array mode the cell takes signed 8-bit operands from its west and north neighbours. It multiplies them, adds the product to its 32-bit running sum, and passes the operands on to the east and south neighbours through one register stage each. A clear strobe starts a new tile: on its own it zeroes the sum, and together with a valid strobe it loads the first product of the tile.

In lane mode the vector engine supplies 32-bit signed operands. The cell returns the low 32 bits of `a*b + c`, or of `a*b` alone for a plain multiply, two cycles later with a one-cycle valid pulse. The running sum of the array is kept unchanged for as long as the vector engine owns the cell.

Top module: `dualmode_mac_cell`

## Requirements
- R1: While `rst_n` is low, `acc_out`, `east_a`, `south_b` and `lane_res` read zero and `lane_res_vld` is low.
- R2: The mode input `lane_mode` is registered, and the registered copy is the effective mode. Array mode is in effect in a cycle when `lane_mode` was low in the previous cycle. In that case, if `arr_vld` is high and `arr_clr` is low, `acc_out` in the next cycle equals the previous sum plus the product of the two's-complement 8-bit `west_a` and `north_b`, taken modulo 2^32.
- R3: With array mode in effect, `arr_clr` high and `arr_vld` low set `acc_out` to zero in the next cycle. `arr_clr` and `arr_vld` both high set it to the product of `west_a` and `north_b` alone.
- R4: With array mode in effect, `arr_vld` and `arr_clr` both low leave `acc_out` unchanged.
- R5: With array mode in effect, `east_a` and `south_b` in the next cycle equal this cycle's `west_a` and `north_b`. With lane mode in effect, both outputs hold their values.
- R6: While lane mode is in effect, the array inputs are ignored and `acc_out` keeps its value. A change of `lane_mode` takes effect one cycle later, so array inputs presented in the cycle that `lane_mode` rises are still accumulated, and those presented in the cycle it falls are ignored.
- R7: If `lane_vld` and `lane_mode` are both high in cycle t, then in cycle t+2 `lane_res_vld` is high and `lane_res` holds the low 32 bits of `lane_a*lane_b + lane_c`. Operations may be issued back to back, one per cycle.
- R8: When `lane_add` is low for an operation, the addend is zero and `lane_res` is the low 32 bits of `lane_a*lane_b`.
- R9: If `lane_vld` is high while `lane_mode` is low, the operation is ignored: no valid pulse follows and `lane_res` does not change.
- R10: `lane_res_vld` is high for exactly one cycle per accepted operation, and `lane_res` holds its last result while `lane_res_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_mode | input | 1 | High while the vector engine owns the cell |
| arr_vld | input | 1 | Array operands are valid; accumulate their product |
| arr_clr | input | 1 | Start of tile: zero the sum, or load the product if `arr_vld` is also high |
| west_a | input | 8 | Signed row operand from the west neighbour |
| north_b | input | 8 | Signed column operand from the north neighbour |
| east_a | output | 8 | Row operand registered and passed to the east neighbour |
| south_b | output | 8 | Column operand registered and passed to the south neighbour |
| acc_out | output | 32 | Running sum of the array |
| lane_vld | input | 1 | Lane operation request |
| lane_add | input | 1 | 1: multiply-add, 0: multiply only |
| lane_a | input | 32 | Signed lane multiplicand |
| lane_b | input | 32 | Signed lane multiplier |
| lane_c | input | 32 | Signed lane addend |
| lane_res | output | 32 | Lane result (low 32 bits) |
| lane_res_vld | output | 1 | One-cycle pulse when `lane_res` is new |

## Verification
Some properties are checked by the assertions on every cycle:
- the sum is held while lane mode is in effect or while the array is idle;
- a lone clear zeroes the sum;
- operands are forwarded with one cycle of delay, or held in lane mode;
- the lane valid pulse follows an accepted request exactly two cycles later;
- `lane_res` holds between pulses.

Other behaviour needs the bench's scenarios, which compute expected values arithmetically. These are the numerical values of the sums over every pair of 8-bit operands and of the lane results across signed boundary values with and without the addend. The same applies to the one-cycle deferral of a mode change in each direction.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

   typedef enum logic {
      MODE_ARRAY = 1'b0,
      MODE_LANE  = 1'b1
   } dmac_mode_e;

   function automatic int unsigned wmax(input int unsigned x, input int unsigned y);
      return (x > y) ? x : y;
   endfunction

endpackage

// File: rtl/dmac_fwd.sv
module dmac_fwd #(
   parameter int unsigned W = 8,
   parameter int unsigned N = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic [N-1:0][W-1:0] d,
   output logic [N-1:0][W-1:0] q
);
   for (genvar g = 0; g < N; g++) begin : g_port
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  q[g] <= '0;
         else if (en) q[g] <= d[g];
      end
   end
endmodule

// File: rtl/dmac_opsel.sv
module dmac_opsel #(
   parameter int unsigned ARR_W  = 8,
   parameter int unsigned ACC_W  = 32,
   parameter int unsigned LANE_W = 32,
   parameter int unsigned MW     = 32
) (
   input  logic              sel_lane,
   input  logic [ARR_W-1:0]  arr_a,
   input  logic [ARR_W-1:0]  arr_b,
   input  logic              arr_clr,
   input  logic [ACC_W-1:0]  acc_q,
   input  logic [LANE_W-1:0] s1_a,
   input  logic [LANE_W-1:0] s1_b,
   input  logic [LANE_W-1:0] s1_c,
   input  logic              s1_add,
   output logic [MW-1:0]     y
);
   logic signed [MW-1:0] ea, eb, eacc, la, lb, lc;
   logic signed [MW-1:0] mul_x, mul_y, mul_z;

   assign ea   = MW'($signed(arr_a));
   assign eb   = MW'($signed(arr_b));
   assign eacc = MW'($signed(acc_q));
   assign la   = MW'($signed(s1_a));
   assign lb   = MW'($signed(s1_b));
   assign lc   = MW'($signed(s1_c));

   always_comb begin
      if (sel_lane) begin
         mul_x = la;
         mul_y = lb;
         mul_z = s1_add ? lc : '0;
      end else begin
         mul_x = ea;
         mul_y = eb;
         mul_z = arr_clr ? '0 : eacc;
      end
   end

   // the one shared multiply-add
   assign y = mul_x * mul_y + mul_z;
endmodule

// File: rtl/dmac_acc.sv
module dmac_acc #(
   parameter int unsigned ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd,
   input  logic             zero,
   input  logic [ACC_W-1:0] y_acc,
   output logic [ACC_W-1:0] acc_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_q <= '0;
      else if (upd)   acc_q <= zero ? '0 : y_acc;
   end
endmodule

// File: rtl/dmac_lane_pipe.sv
module dmac_lane_pipe #(
   parameter int unsigned LANE_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              add_in,
   input  logic [LANE_W-1:0] a_in,
   input  logic [LANE_W-1:0] b_in,
   input  logic [LANE_W-1:0] c_in,
   output logic [LANE_W-1:0] s1_a,
   output logic [LANE_W-1:0] s1_b,
   output logic [LANE_W-1:0] s1_c,
   output logic              s1_add,
   input  logic [LANE_W-1:0] y_lane,
   output logic [LANE_W-1:0] res,
   output logic              res_vld
);
   logic s1_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld <= 1'b0;
         s1_add <= 1'b0;
         s1_a   <= '0;
         s1_b   <= '0;
         s1_c   <= '0;
      end else begin
         s1_vld <= req;
         if (req) begin
            s1_add <= add_in;
            s1_a   <= a_in;
            s1_b   <= b_in;
            s1_c   <= c_in;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res     <= '0;
         res_vld <= 1'b0;
      end else begin
         res_vld <= s1_vld;
         if (s1_vld) res <= y_lane;
      end
   end
endmodule

// File: rtl/dualmode_mac_cell.sv
module dualmode_mac_cell #(
   parameter int unsigned ARR_W  = 8,
   parameter int unsigned ACC_W  = 32,
   parameter int unsigned LANE_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lane_mode,
   input  logic              arr_vld,
   input  logic              arr_clr,
   input  logic [ARR_W-1:0]  west_a,
   input  logic [ARR_W-1:0]  north_b,
   output logic [ARR_W-1:0]  east_a,
   output logic [ARR_W-1:0]  south_b,
   output logic [ACC_W-1:0]  acc_out,
   input  logic              lane_vld,
   input  logic              lane_add,
   input  logic [LANE_W-1:0] lane_a,
   input  logic [LANE_W-1:0] lane_b,
   input  logic [LANE_W-1:0] lane_c,
   output logic [LANE_W-1:0] lane_res,
   output logic              lane_res_vld
);
   import dmac_pkg::*;

   localparam int unsigned MW = wmax(ACC_W, LANE_W);

   if (ARR_W < 2) begin : g_bad_arr
      $error("ARR_W must be at least 2");
   end
   if (2 * ARR_W > ACC_W) begin : g_bad_acc
      $error("ACC_W must hold a full array product");
   end
   if (LANE_W < 2) begin : g_bad_lane
      $error("LANE_W must be at least 2");
   end

   dmac_mode_e mode_q;
   logic       lane_eff;
   logic       arr_upd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_ARRAY;
      else        mode_q <= lane_mode ? MODE_LANE : MODE_ARRAY;
   end

   assign lane_eff = (mode_q == MODE_LANE);
   assign arr_upd  = !lane_eff && (arr_vld || arr_clr);

   logic [1:0][ARR_W-1:0] fwd_d, fwd_q;
   assign fwd_d   = {north_b, west_a};
   assign east_a  = fwd_q[0];
   assign south_b = fwd_q[1];

   dmac_fwd #(.W(ARR_W), .N(2)) i_fwd (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (!lane_eff),
      .d    (fwd_d),
      .q    (fwd_q)
   );

   logic [LANE_W-1:0] s1_a, s1_b, s1_c;
   logic              s1_add;
   logic [MW-1:0]     y;

   dmac_opsel #(.ARR_W(ARR_W), .ACC_W(ACC_W), .LANE_W(LANE_W), .MW(MW)) i_opsel (
      .sel_lane(lane_eff),
      .arr_a   (west_a),
      .arr_b   (north_b),
      .arr_clr (arr_clr),
      .acc_q   (acc_out),
      .s1_a    (s1_a),
      .s1_b    (s1_b),
      .s1_c    (s1_c),
      .s1_add  (s1_add),
      .y       (y)
   );

   dmac_acc #(.ACC_W(ACC_W)) i_acc (
      .clk  (clk),
      .rst_n(rst_n),
      .upd  (arr_upd),
      .zero (arr_clr && !arr_vld),
      .y_acc(y[ACC_W-1:0]),
      .acc_q(acc_out)
   );

   dmac_lane_pipe #(.LANE_W(LANE_W)) i_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (lane_vld && lane_mode),
      .add_in (lane_add),
      .a_in   (lane_a),
      .b_in   (lane_b),
      .c_in   (lane_c),
      .s1_a   (s1_a),
      .s1_b   (s1_b),
      .s1_c   (s1_c),
      .s1_add (s1_add),
      .y_lane (y[LANE_W-1:0]),
      .res    (lane_res),
      .res_vld(lane_res_vld)
   );
endmodule

// File: rtl/dmac_checker.sv
module dmac_checker #(
   parameter int unsigned ARR_W  = 8,
   parameter int unsigned ACC_W  = 32,
   parameter int unsigned LANE_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lane_eff,
   input logic              lane_mode,
   input logic              arr_vld,
   input logic              arr_clr,
   input logic              lane_vld,
   input logic [ARR_W-1:0]  west_a,
   input logic [ARR_W-1:0]  north_b,
   input logic [ARR_W-1:0]  east_a,
   input logic [ARR_W-1:0]  south_b,
   input logic [ACC_W-1:0]  acc_out,
   input logic [LANE_W-1:0] lane_res,
   input logic              lane_res_vld
);
   assert_acc_kept_in_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lane_eff |=> $stable(acc_out));

   assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!arr_vld && !arr_clr) |=> $stable(acc_out));

   assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!lane_eff && arr_clr && !arr_vld) |=> (acc_out == '0));

   assert_fwd_east_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_eff |=> (east_a == $past(west_a)));

   assert_fwd_south_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_eff |=> (south_b == $past(north_b)));

   assert_fwd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lane_eff |=> ($stable(east_a) && $stable(south_b)));

   assert_lane_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_vld && lane_mode) |=> ##1 lane_res_vld);

   assert_lane_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(lane_vld && lane_mode) |=> ##1 !lane_res_vld);

   assert_res_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_res_vld |-> $stable(lane_res));
endmodule

bind dualmode_mac_cell dmac_checker #(.ARR_W(ARR_W), .ACC_W(ACC_W), .LANE_W(LANE_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .lane_eff    (lane_eff),
   .lane_mode   (lane_mode),
   .arr_vld     (arr_vld),
   .arr_clr     (arr_clr),
   .lane_vld    (lane_vld),
   .west_a      (west_a),
   .north_b     (north_b),
   .east_a      (east_a),
   .south_b     (south_b),
   .acc_out     (acc_out),
   .lane_res    (lane_res),
   .lane_res_vld(lane_res_vld)
);

// File: tb/test_dualmode_mac_cell.sv
module test_dualmode_mac_cell;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lane_mode = 1'b0, arr_vld = 1'b0, arr_clr = 1'b0;
   logic [7:0]  west_a = '0, north_b = '0;
   logic [7:0]  east_a, south_b;
   logic [31:0] acc_out;
   logic        lane_vld = 1'b0, lane_add = 1'b0;
   logic [31:0] lane_a = '0, lane_b = '0, lane_c = '0;
   logic [31:0] lane_res;
   logic        lane_res_vld;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dualmode_mac_cell i_dualmode_mac_cell (
      .clk(clk), .rst_n(rst_n), .lane_mode(lane_mode), .arr_vld(arr_vld), .arr_clr(arr_clr),
      .west_a(west_a), .north_b(north_b), .east_a(east_a), .south_b(south_b), .acc_out(acc_out),
      .lane_vld(lane_vld), .lane_add(lane_add), .lane_a(lane_a), .lane_b(lane_b), .lane_c(lane_c),
      .lane_res(lane_res), .lane_res_vld(lane_res_vld)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] prod8(input logic [7:0] a, input logic [7:0] b);
      byte sa, sb;
      sa = byte'(a);
      sb = byte'(b);
      return 32'(int'(sa) * int'(sb));
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] m;
      logic [31:0] vals [8];
      logic [31:0] p_exp, held;
      logic        p_vld;

      vals[0] = 32'd0;          vals[1] = 32'd1;
      vals[2] = 32'hFFFF_FFFF;  vals[3] = 32'd2;
      vals[4] = 32'h7FFF_FFFF;  vals[5] = 32'h8000_0000;
      vals[6] = 32'd12345;      vals[7] = 32'hFFFF_FCF7;

      repeat (3) @(negedge clk);
      check("R1 acc", acc_out, 32'd0);
      check("R1 east", {24'd0, east_a}, 32'd0);
      check("R1 south", {24'd0, south_b}, 32'd0);
      check("R1 lane_res", lane_res, 32'd0);
      check("R1 lane_res_vld", {31'd0, lane_res_vld}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2/R3/R5: sweep every operand pair; clear+load every 4096 pairs
      m = '0;
      for (int i = 0; i < 65536; i++) begin
         west_a  = i[15:8];
         north_b = i[7:0];
         arr_vld = 1'b1;
         arr_clr = (i % 4096 == 0);
         if (arr_clr) m = prod8(west_a, north_b);
         else         m = m + prod8(west_a, north_b);
         @(negedge clk);
         check(arr_clr ? "R3 load" : "R2 accumulate", acc_out, m);
         check("R5 east", {24'd0, east_a}, {24'd0, i[15:8]});
         check("R5 south", {24'd0, south_b}, {24'd0, i[7:0]});
      end

      // R3: lone clear
      arr_vld = 1'b0; arr_clr = 1'b1; west_a = 8'd9; north_b = 8'd9;
      @(negedge clk);
      check("R3 clear", acc_out, 32'd0);

      // R3 load with extreme operands, then R4 idle
      arr_vld = 1'b1; arr_clr = 1'b1; west_a = 8'h80; north_b = 8'h80;
      @(negedge clk);
      check("R3 load min*min", acc_out, 32'd16384);
      arr_vld = 1'b0; arr_clr = 1'b0; west_a = 8'd5; north_b = 8'd7;
      @(negedge clk);
      check("R4 idle hold", acc_out, 32'd16384);
      check("R5 fwd while idle", {24'd0, east_a}, 32'd5);
      @(negedge clk);
      check("R4 idle hold 2", acc_out, 32'd16384);

      // R6: array inputs in the cycle lane_mode rises still count
      lane_mode = 1'b1; arr_vld = 1'b1; west_a = 8'd3; north_b = 8'd4;
      @(negedge clk);
      check("R6 deferred entry", acc_out, 32'd16396);
      check("R5 east", {24'd0, east_a}, 32'd3);
      arr_clr = 1'b1; west_a = 8'd9; north_b = 8'd9;
      @(negedge clk);
      check("R6 ignored in lane", acc_out, 32'd16396);
      check("R5 hold east", {24'd0, east_a}, 32'd3);
      check("R5 hold south", {24'd0, south_b}, 32'd4);

      // R7/R8/R10: lane sweep over boundary values, back to back, with gaps
      p_vld = 1'b0; p_exp = '0; held = '0;
      for (int n = 0; n <= 512; n++) begin
         logic [31:0] e;
         if (n < 512) begin
            lane_vld = (n % 5 != 4);
            lane_add = (n % 3 != 0);
            lane_a   = vals[n / 64];
            lane_b   = vals[(n / 8) % 8];
            lane_c   = vals[n % 8];
            e = lane_a * lane_b + (lane_add ? lane_c : 32'd0);
         end else begin
            lane_vld = 1'b0;
            e = '0;
         end
         @(negedge clk);
         if (n > 0) begin
            check("R10 valid pulse", {31'd0, lane_res_vld}, {31'd0, p_vld});
            if (p_vld) begin
               held = p_exp;
               check(lane_add ? "R7 multiply-add" : "R8 multiply", lane_res, p_exp);
            end else begin
               check("R10 hold", lane_res, held);
            end
         end
         check("R6 acc kept", acc_out, 32'd16396);
         p_vld = lane_vld;
         p_exp = e;
      end
      @(negedge clk);
      check("R10 single pulse", {31'd0, lane_res_vld}, 32'd0);

      // R6 exit deferral + R9 lane request while mode low
      lane_mode = 1'b0; arr_clr = 1'b0; arr_vld = 1'b1; west_a = 8'd2; north_b = 8'd2;
      lane_vld = 1'b1; lane_add = 1'b1; lane_a = 32'd5; lane_b = 32'd5; lane_c = 32'd1;
      @(negedge clk);
      check("R6 deferred exit", acc_out, 32'd16396);
      lane_vld = 1'b0;
      @(negedge clk);
      check("R6 array resumes", acc_out, 32'd16400);
      check("R9 no pulse", {31'd0, lane_res_vld}, 32'd0);
      check("R9 result kept", lane_res, held);
      arr_vld = 1'b0;
      @(negedge clk);
      check("R9 still no pulse", {31'd0, lane_res_vld}, 32'd0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule